// File: doc/BRIEF.md
# External interrupt pin conditioner

This block sits between one active-low external interrupt request pin and the chip's interrupt logic. It brings the asynchronous pin into the clock domain, then presents a request to the interrupt logic in one of two ways. In level mode the request follows the pin while the pin is low. In edge mode each falling edge sets a pending flag, and that flag holds the request until the interrupt logic acknowledges service.

Software controls the block through one 8-bit control register on a simple write-strobe bus. One bit in that register selects the sensitivity and another connects or disconnects the pin. How often the sensitivity bit may be written depends on a chip mode input. In special mode it can be changed at any time. In normal and emulation modes only the first write after reset has any effect, so the choice cannot be changed by accident once it is made.

Top module: `irq_pin_cond`

## Requirements
- R1: With sensitivity 0 (level mode) and enable 1, `irq_req` is high exactly while the pin value, delayed through two register stages, is low. A change on `irq_pin_n` shows on `irq_req` after the second rising clock edge.
- R2: With enable 0, `irq_req` is always 0. Enable is bit 6 of the control register and can be written in every mode.
- R3: With sensitivity 1 (edge mode), a 1-to-0 transition of the synchronised pin sets a pending latch on the next edge. This is the third rising edge after the pin falls. `irq_req` then equals the latch while enable is 1.
- R4: In edge mode the pending latch stays set until `svc_ack` or reset. Holding the pin low, or taking it high, raises no new request.
- R5: In normal mode (`mode`=00), emulation mode (`mode`=01) and the unused code 11, the first write after reset sets the sensitivity bit (bit 7). Every later write leaves that bit unchanged.
- R6: In special mode (`mode`=10) every write updates the sensitivity bit and does not use up the one allowed write.
- R7: A one-cycle `svc_ack` clears the pending latch. If a falling edge is detected in the same cycle as the acknowledge, the latch stays set.
- R8: After reset the control register reads 0x40 (level mode, enabled), the pending latch is clear, and the first write is still available.
- R9: `reg_rdata` is {sensitivity, enable, 6'b0} at all times. Bits 5 to 0 read 0 whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_n | input | 1 | Asynchronous interrupt pin, active low |
| mode | input | 2 | Chip mode: 00 normal, 01 emulation, 10 special, 11 treated as normal |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data: bit 7 sensitivity, bit 6 enable |
| reg_rdata | output | 8 | Control register read value |
| svc_ack | input | 1 | One-cycle service acknowledge |
| irq_req | output | 1 | Conditioned request to the interrupt logic |

## Verification
The assertions assume three things about the inputs:
- `mode` and `reg_wdata` are valid whenever `reg_wr` is high.
- `svc_ack` is a single-cycle pulse.
- `irq_pin_n` changes far enough apart for the synchroniser to register each level.

The stimulus drives every input one time unit after a rising edge. It holds each pin level for at least three cycles, and it pulses the acknowledge for exactly one cycle. One acknowledge is placed deliberately in the cycle where a fresh falling edge is detected, to exercise the case where the edge wins.

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int SENSE_BIT   = 7,
  parameter int ENABLE_BIT  = 6,
  parameter logic [1:0] MODE_SPECIAL = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin_n,
  input  logic [1:0]        mode,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              svc_ack,
  output logic              irq_req
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;
  logic                   sense, en, pend, locked;

  wire pin_s   = chain[SYNC_STAGES-1];
  wire fall    = prev & ~pin_s;
  wire special = (mode == MODE_SPECIAL);
  wire sense_w = reg_wr & (special | ~locked);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], irq_pin_n};
      prev  <= pin_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sense  <= 1'b0;
      en     <= 1'b1;
      locked <= 1'b0;
    end else if (reg_wr) begin
      en <= reg_wdata[ENABLE_BIT];
      if (sense_w) sense <= reg_wdata[SENSE_BIT];
      if (!special) locked <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              pend <= 1'b0;
    else if (sense && fall)  pend <= 1'b1;
    else if (svc_ack)        pend <= 1'b0;

  always_comb begin
    reg_rdata = '0;
    reg_rdata[SENSE_BIT]  = sense;
    reg_rdata[ENABLE_BIT] = en;
  end

  assign irq_req = en & (sense ? pend : ~pin_s);

  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sense && fall) |=> pend);
  assert_pend_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !svc_ack) |=> pend);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && svc_ack && !(sense && fall)) |=> !pend);
  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !special) |=> $stable(sense));
  assert_enable_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[ENABLE_BIT] == $past(reg_wdata[ENABLE_BIT])));
  assert_special_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && special) |=> (reg_rdata[SENSE_BIT] == $past(reg_wdata[SENSE_BIT])));
  assert_low_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:0] == 6'b0);

endmodule

// File: tb/sim_irq_pin_cond.sv
module sim_irq_pin_cond;
  logic clk = 0, rst_n = 0, irq_pin_n = 1, reg_wr = 0, svc_ack = 0;
  logic [1:0] mode = 2'b00;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_req;
  int compared = 0, mismatched = 0;
  string req_tag = "R8";
  bit done = 0;

  always #2 clk = ~clk;

  irq_pin_cond u0 (.clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .mode(mode),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .svc_ack(svc_ack), .irq_req(irq_req));

  bit q[$];
  bit m_sense, m_en, m_pend, m_once;
  bit m_fall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = '{1, 1, 1}; m_sense = 0; m_en = 1; m_pend = 0; m_once = 0;
    end else begin
      m_fall = (q[2] == 1) && (q[1] == 0);
      if (m_sense && m_fall) m_pend = 1;
      else if (svc_ack) m_pend = 0;
      if (reg_wr) begin
        m_en = reg_wdata[6];
        if (mode == 2'b10) m_sense = reg_wdata[7];
        else begin
          if (!m_once) m_sense = reg_wdata[7];
          m_once = 1;
        end
      end
      q.push_front(irq_pin_n);
      void'(q.pop_back());
    end
  end

  function automatic bit model_req();
    return m_en && (m_sense ? m_pend : !q[1]);
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    compared++;
    if (irq_req !== model_req()) begin
      mismatched++;
      $display("FAIL %s irq_req actual=%b expected=%b at %0t", req_tag, irq_req, model_req(), $time);
    end
    compared++;
    if (reg_rdata !== {m_sense, m_en, 6'b0}) begin
      mismatched++;
      $display("FAIL %s reg_rdata actual=%h expected=%h at %0t", req_tag, reg_rdata, {m_sense, m_en, 6'b0}, $time);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(logic [7:0] d);
    reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0;
  endtask
  task automatic ack();
    svc_ack = 1; tick(); svc_ack = 0;
  endtask
  task automatic do_reset();
    rst_n = 0; tick(2); rst_n = 1; tick();
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(2); rst_n = 1;
    req_tag = "R8"; tick(3);                        // R8 reset value 0x40
    req_tag = "R1";                                 // R1 level mode follows pin
    irq_pin_n = 0; tick(5); irq_pin_n = 1; tick(4);
    irq_pin_n = 0; tick(3); irq_pin_n = 1; tick(3);
    req_tag = "R2";                                 // R2 disable gates output
    wr(8'h00); irq_pin_n = 0; tick(5); wr(8'h40); tick(3); irq_pin_n = 1; tick(3);
    req_tag = "R9"; wr(8'h7F); tick(2);             // R9 low bits read zero
    req_tag = "R5"; do_reset(); mode = 2'b00;       // R5 write once, normal mode
    wr(8'hC0); tick(); wr(8'h40); tick(2); wr(8'h00); tick(); wr(8'hC0); tick(2);
    req_tag = "R3";                                 // R3 edge sets latch
    irq_pin_n = 0; tick(6);
    req_tag = "R4";                                 // R4 hold until service
    irq_pin_n = 1; tick(4); irq_pin_n = 0; tick(2);
    req_tag = "R7"; tick(3); ack(); tick(3);         // R7 ack clears
    irq_pin_n = 1; tick(4); irq_pin_n = 0; tick(5); irq_pin_n = 1; tick(4);
    irq_pin_n = 0; tick(2); ack(); tick(4);          // R7 edge wins over ack
    ack(); tick(3); irq_pin_n = 1; tick(3);
    req_tag = "R5"; do_reset(); mode = 2'b01;       // R5 emulation mode
    wr(8'h40); wr(8'hC0); tick(); irq_pin_n = 0; tick(4); irq_pin_n = 1; tick(3);
    do_reset(); mode = 2'b11; wr(8'hC0); wr(8'h40); tick(2);
    req_tag = "R6"; do_reset(); mode = 2'b10;       // R6 special mode rewrites
    wr(8'hC0); tick(); wr(8'h40); tick(); wr(8'hC0); tick();
    irq_pin_n = 0; tick(5); irq_pin_n = 1; tick(3); ack(); tick(2);
    wr(8'h40); mode = 2'b00; wr(8'hC0); wr(8'h40); tick(3);
    req_tag = "R8"; do_reset(); tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule